// File: doc/BRIEF.md
# Half-Bridge Submodule Switch-State Resolver

This block works out which switch of each half-bridge submodule in one converter arm conducts during a single solver step. It takes the commanded gate bits of every submodule and the signed arm current. When a submodule is commanded fully off, it picks the conducting diode from the direction of the current entering that submodule. From the resolved switch states it forms each submodule's terminal voltage and capacitor current. It then adds the terminal voltages of all submodules in the chain to the DC source voltage, with a sign set by the arm position, to give the arm node voltage.

The block sits between the gate command sampler and the capacitor and inductor integrators of a real-time converter model. It is purely algebraic: the integrators supply the capacitor voltages and the arm current, and they consume the capacitor currents and the arm voltage. Every result is registered once, so the outputs show the inputs sampled one clock earlier. Signed fixed point is used throughout. The arm sum is formed in a widened accumulator and clamped to the output width.

Top module: `smres_arm`

## Requirements
- R1: For submodule k, gate pattern `gate_hi[k]=1, gate_lo[k]=0` gives `sw_hi[k]=1, sw_lo[k]=0`, and gate pattern `gate_hi[k]=0, gate_lo[k]=1` gives `sw_hi[k]=0, sw_lo[k]=1`. The current direction has no effect in either case.
- R2: When both gate bits of submodule k are 0, `sw_hi[k]` is 1 if the current entering that submodule is zero or positive and 0 if it is negative. `sw_lo[k]` is the complement of `sw_hi[k]`.
- R3: When both gate bits of submodule k are 1, `fault[k]` is 1 and both `sw_hi[k]` and `sw_lo[k]` are 0. In every other case `fault[k]` is 0.
- R4: Lane k of `sm_volt` (bits k*VW upward) equals the capacitor voltage of lane k when `sw_hi[k]=1`, and is 0 otherwise.
- R5: Lane k of `cap_cur` (bits k*IW upward) equals the current entering submodule k when `sw_hi[k]=1`, and is 0 otherwise.
- R6: The current entering submodule 0 is `arm_cur`. The current entering submodule k+1 equals the current entering submodule k when exactly one switch of k conducts, and is 0 when submodule k is in shoot-through.
- R7: With `lower_arm=0`, `arm_volt` = `dc_volt` minus the sum of all `sm_volt` lanes. With `lower_arm=1`, `arm_volt` = `dc_volt` plus that sum.
- R8: When the exact arm result lies outside the signed VW-bit range, `arm_volt` is clamped to the nearest limit, 2^(VW-1)-1 or -2^(VW-1).
- R9: All outputs are registered once and change only one clock after the inputs that produce them are sampled. While `rst` is high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gate_hi | input | NSM | Gate command of the switch that inserts the capacitor, one bit per submodule |
| gate_lo | input | NSM | Gate command of the bypass switch, one bit per submodule |
| arm_cur | input | IW | Signed arm inductor current |
| cap_volt | input | NSM*VW | Signed capacitor voltages, lane k at bits k*VW upward |
| dc_volt | input | VW | Signed DC source voltage |
| lower_arm | input | 1 | 0 = upper arm (subtract sum), 1 = lower arm (add sum) |
| sw_hi | output | NSM | Effective state of the inserting switch |
| sw_lo | output | NSM | Effective state of the bypass switch |
| fault | output | NSM | Shoot-through flag per submodule |
| sm_volt | output | NSM*VW | Signed submodule terminal voltages |
| cap_cur | output | NSM*IW | Signed capacitor currents |
| arm_volt | output | VW | Signed, saturated arm node voltage |

## Verification
The hardest case to reach is a submodule in the dead zone whose diode choice depends on a current that an upstream shoot-through has already zeroed. That submodule must then choose the inserting path and still carry zero capacitor current. Directed steps place a shoot-through in the middle of the chain, drive a negative arm current and leave the downstream gates off. This makes the zeroed current visible in both the switch states and the capacitor current lanes. Directed steps with large capacitor voltages drive both clamp limits, and long pseudo-random runs mix all four gate patterns per submodule with both arm positions.

// File: rtl/smres_pkg.sv
package smres_pkg;

    // gate command pattern, packed as {hi, lo}
    typedef enum logic [1:0] {
        GATE_DEAD  = 2'b00,
        GATE_BYP   = 2'b01,
        GATE_INS   = 2'b10,
        GATE_SHORT = 2'b11
    } gate_pat_t;

    typedef struct packed {
        logic hi;
        logic lo;
        logic fault;
    } sw_state_t;

    // resolve conduction from gate pattern and the sign of the entering current
    function automatic sw_state_t resolve_sw(input logic g_hi, input logic g_lo,
                                             input logic cur_neg);
        sw_state_t r;
        r = '{hi: 1'b0, lo: 1'b0, fault: 1'b0};
        case (gate_pat_t'({g_hi, g_lo}))
            GATE_INS:   r.hi = 1'b1;
            GATE_BYP:   r.lo = 1'b1;
            GATE_SHORT: r.fault = 1'b1;
            default: begin
                r.hi = ~cur_neg;
                r.lo = cur_neg;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/smres_cell.sv
module smres_cell
    import smres_pkg::*;
#(
    parameter int VW = 16,
    parameter int IW = 16
) (
    input  logic                 g_hi,
    input  logic                 g_lo,
    input  logic signed [IW-1:0] cur_in,
    input  logic signed [VW-1:0] cap_v,
    output sw_state_t            st,
    output logic signed [VW-1:0] v_out,
    output logic signed [IW-1:0] i_cap,
    output logic signed [IW-1:0] cur_out
);

    always_comb begin
        st      = resolve_sw(g_hi, g_lo, cur_in[IW-1]);
        v_out   = st.hi ? cap_v : '0;
        i_cap   = st.hi ? cur_in : '0;
        cur_out = (st.hi || st.lo) ? cur_in : '0;
    end

endmodule

// File: rtl/smres_arm_sum.sv
module smres_arm_sum #(
    parameter int NSM = 4,
    parameter int VW  = 16
) (
    input  logic [NSM*VW-1:0]    v_lanes,
    input  logic signed [VW-1:0] v_dc,
    input  logic                 add_mode,
    output logic signed [VW-1:0] v_arm,
    output logic                 clamped
);

    localparam int AW = VW + $clog2(NSM) + 2;
    localparam logic signed [AW-1:0] SAT_HI = {{(AW-VW+1){1'b0}}, {(VW-1){1'b1}}};
    localparam logic signed [AW-1:0] SAT_LO = {{(AW-VW+1){1'b1}}, {(VW-1){1'b0}}};

    logic signed [AW-1:0] lane_sum;
    logic signed [AW-1:0] total;

    always_comb begin
        lane_sum = '0;
        for (int k = 0; k < NSM; k++) begin
            lane_sum = lane_sum + AW'($signed(v_lanes[k*VW +: VW]));
        end
        total = add_mode ? (AW'(v_dc) + lane_sum) : (AW'(v_dc) - lane_sum);
        if (total > SAT_HI) begin
            v_arm   = SAT_HI[VW-1:0];
            clamped = 1'b1;
        end else if (total < SAT_LO) begin
            v_arm   = SAT_LO[VW-1:0];
            clamped = 1'b1;
        end else begin
            v_arm   = total[VW-1:0];
            clamped = 1'b0;
        end
    end

endmodule

// File: rtl/smres_arm.sv
module smres_arm
    import smres_pkg::*;
#(
    parameter int NSM = 4,
    parameter int VW  = 16,
    parameter int IW  = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NSM-1:0]        gate_hi,
    input  logic [NSM-1:0]        gate_lo,
    input  logic signed [IW-1:0]  arm_cur,
    input  logic [NSM*VW-1:0]     cap_volt,
    input  logic signed [VW-1:0]  dc_volt,
    input  logic                  lower_arm,
    output logic [NSM-1:0]        sw_hi,
    output logic [NSM-1:0]        sw_lo,
    output logic [NSM-1:0]        fault,
    output logic [NSM*VW-1:0]     sm_volt,
    output logic [NSM*IW-1:0]     cap_cur,
    output logic signed [VW-1:0]  arm_volt
);

    logic signed [IW-1:0] chain_cur [NSM+1];
    sw_state_t            st_c [NSM];
    logic [NSM*VW-1:0]    vout_c;
    logic [NSM*IW-1:0]    icap_c;
    logic signed [VW-1:0] arm_c;
    logic                 arm_clamped;
    logic                 primed;

    assign chain_cur[0] = arm_cur;

    for (genvar k = 0; k < NSM; k++) begin : g_cell
        logic signed [VW-1:0] v_k;
        logic signed [IW-1:0] i_k;
        smres_cell #(.VW(VW), .IW(IW)) u_cell (
            .g_hi    (gate_hi[k]),
            .g_lo    (gate_lo[k]),
            .cur_in  (chain_cur[k]),
            .cap_v   ($signed(cap_volt[k*VW +: VW])),
            .st      (st_c[k]),
            .v_out   (v_k),
            .i_cap   (i_k),
            .cur_out (chain_cur[k+1])
        );
        assign vout_c[k*VW +: VW] = v_k;
        assign icap_c[k*IW +: IW] = i_k;
    end

    smres_arm_sum #(.NSM(NSM), .VW(VW)) u_sum (
        .v_lanes  (vout_c),
        .v_dc     (dc_volt),
        .add_mode (lower_arm),
        .v_arm    (arm_c),
        .clamped  (arm_clamped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_hi    <= '0;
            sw_lo    <= '0;
            fault    <= '0;
            sm_volt  <= '0;
            cap_cur  <= '0;
            arm_volt <= '0;
            primed   <= 1'b0;
        end else begin
            for (int k = 0; k < NSM; k++) begin
                sw_hi[k] <= st_c[k].hi;
                sw_lo[k] <= st_c[k].lo;
                fault[k] <= st_c[k].fault;
            end
            sm_volt  <= vout_c;
            cap_cur  <= icap_c;
            arm_volt <= arm_c;
            primed   <= 1'b1;
        end
    end

    // clamped flag is informational inside the arm summer; it must never
    // coincide with an in-range registered value that is not a limit
    logic clamp_q;
    always_ff @(posedge clk) begin
        if (rst) clamp_q <= 1'b0;
        else     clamp_q <= arm_clamped;
    end

    for (genvar k = 0; k < NSM; k++) begin : g_chk
        assert_commanded_R1: assert property (@(posedge clk) disable iff (rst)
            primed && $past(gate_hi[k] && !gate_lo[k]) |-> sw_hi[k] && !sw_lo[k]);
        assert_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
            $onehot0({sw_hi[k], sw_lo[k]}));
        assert_shoot_off_R3: assert property (@(posedge clk) disable iff (rst)
            fault[k] |-> !sw_hi[k] && !sw_lo[k]);
        assert_vout_gated_R4: assert property (@(posedge clk) disable iff (rst)
            !sw_hi[k] |-> sm_volt[k*VW +: VW] == '0);
        assert_icap_gated_R5: assert property (@(posedge clk) disable iff (rst)
            !sw_hi[k] |-> cap_cur[k*IW +: IW] == '0);
    end

    assert_clamp_limit_R8: assert property (@(posedge clk) disable iff (rst)
        clamp_q |-> (arm_volt == {1'b0, {(VW-1){1'b1}}}) || (arm_volt == {1'b1, {(VW-1){1'b0}}}));

    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        primed && $stable(gate_hi) && $stable(gate_lo) && $stable(arm_cur) &&
        $stable(cap_volt) && $stable(dc_volt) && $stable(lower_arm) && $past(primed)
        |=> $stable(arm_volt) && $stable(sw_hi) && $stable(sw_lo));

endmodule

// File: tb/smres_arm_tb.sv
module smres_arm_tb;

    localparam int NSM = 4;
    localparam int VW  = 16;
    localparam int IW  = 16;
    localparam int VMAX = (1 << (VW - 1)) - 1;
    localparam int VMIN = -(1 << (VW - 1));

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NSM-1:0]       gate_hi = '0;
    logic [NSM-1:0]       gate_lo = '0;
    logic signed [IW-1:0] arm_cur = '0;
    logic [NSM*VW-1:0]    cap_volt = '0;
    logic signed [VW-1:0] dc_volt = '0;
    logic                 lower_arm = 1'b0;
    logic [NSM-1:0]       sw_hi, sw_lo, fault;
    logic [NSM*VW-1:0]    sm_volt;
    logic [NSM*IW-1:0]    cap_cur;
    logic signed [VW-1:0] arm_volt;

    int n_cmp = 0;
    int n_bad = 0;

    // expected values from the behavioural model
    int e_hi [NSM], e_lo [NSM], e_flt [NSM], e_v [NSM], e_i [NSM];
    int e_arm = 0;
    bit e_sat = 0;
    bit e_zeroed [NSM];
    string e_tag [NSM];

    always #2.5 clk = ~clk;

    smres_arm #(.NSM(NSM), .VW(VW), .IW(IW)) u_dut (
        .clk(clk), .rst(rst), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .arm_cur(arm_cur), .cap_volt(cap_volt), .dc_volt(dc_volt),
        .lower_arm(lower_arm), .sw_hi(sw_hi), .sw_lo(sw_lo), .fault(fault),
        .sm_volt(sm_volt), .cap_cur(cap_cur), .arm_volt(arm_volt)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model();
        int cur = $signed(arm_cur);
        int sum = 0;
        int tot;
        for (int k = 0; k < NSM; k++) begin
            int cv = $signed(cap_volt[k*VW +: VW]);
            e_zeroed[k] = (cur != $signed(arm_cur));
            e_flt[k] = 0; e_hi[k] = 0; e_lo[k] = 0;
            if (gate_hi[k] && gate_lo[k]) begin
                e_flt[k] = 1; e_tag[k] = "R3";
            end else if (gate_hi[k]) begin
                e_hi[k] = 1; e_tag[k] = "R1";
            end else if (gate_lo[k]) begin
                e_lo[k] = 1; e_tag[k] = "R1";
            end else begin
                e_hi[k] = (cur >= 0) ? 1 : 0;
                e_lo[k] = 1 - e_hi[k];
                e_tag[k] = "R2";
            end
            e_v[k] = e_hi[k] ? cv : 0;
            e_i[k] = e_hi[k] ? cur : 0;
            if (e_flt[k] == 1) cur = 0;
            sum += e_v[k];
        end
        tot = lower_arm ? ($signed(dc_volt) + sum) : ($signed(dc_volt) - sum);
        e_sat = (tot > VMAX) || (tot < VMIN);
        e_arm = (tot > VMAX) ? VMAX : ((tot < VMIN) ? VMIN : tot);
    endtask

    task automatic compare_all();
        for (int k = 0; k < NSM; k++) begin
            check(e_tag[k], $sformatf("sw_hi[%0d]", k), int'(sw_hi[k]), e_hi[k]);
            check(e_tag[k], $sformatf("sw_lo[%0d]", k), int'(sw_lo[k]), e_lo[k]);
            check("R3", $sformatf("fault[%0d]", k), int'(fault[k]), e_flt[k]);
            check("R4", $sformatf("sm_volt[%0d]", k), $signed(sm_volt[k*VW +: VW]), e_v[k]);
            check(e_zeroed[k] ? "R6" : "R5", $sformatf("cap_cur[%0d]", k),
                  $signed(cap_cur[k*IW +: IW]), e_i[k]);
        end
        check(e_sat ? "R8" : "R7", "arm_volt", int'(arm_volt), e_arm);
    endtask

    // inputs are set at a negedge; outputs must hold until the next posedge (R9)
    task automatic step();
        int prev_arm = e_arm;
        #1;
        check("R9", "arm_volt before edge", int'(arm_volt), prev_arm);
        model();
        @(negedge clk);
        compare_all();
    endtask

    task automatic set_cv(input int a, input int b, input int c, input int d);
        cap_volt[0*VW +: VW] = VW'(a);
        cap_volt[1*VW +: VW] = VW'(b);
        cap_volt[2*VW +: VW] = VW'(c);
        cap_volt[3*VW +: VW] = VW'(d);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        gate_hi = 4'b1111; gate_lo = 4'b0101; arm_cur = 16'sd77;
        set_cv(100, 200, 300, 400); dc_volt = 16'sd500;
        repeat (3) @(negedge clk);
        // R9: reset holds all outputs at zero
        check("R9", "sw_hi in reset", int'(sw_hi), 0);
        check("R9", "sw_lo in reset", int'(sw_lo), 0);
        check("R9", "fault in reset", int'(fault), 0);
        check("R9", "sm_volt in reset", int'(sm_volt != '0), 0);
        check("R9", "cap_cur in reset", int'(cap_cur != '0), 0);
        check("R9", "arm_volt in reset", int'(arm_volt), 0);
        rst = 1'b0;
        e_arm = 0;

        // R1: inserting pattern, upper arm
        gate_hi = '1; gate_lo = '0; arm_cur = 16'sd100; lower_arm = 0;
        set_cv(1000, 2000, 3000, 4000); dc_volt = 16'sd20000;
        step();
        arm_cur = -16'sd100; step();
        // R1: bypass pattern, sign irrelevant
        gate_hi = '0; gate_lo = '1; arm_cur = -16'sd50; step();
        arm_cur = 16'sd50; step();
        // R2: dead zone for positive, negative and zero current
        gate_hi = '0; gate_lo = '0; arm_cur = 16'sd300; step();
        arm_cur = -16'sd300; step();
        arm_cur = 16'sd0; step();
        // R3 and R6: shoot-through mid-chain zeroes downstream current
        gate_hi = 4'b0010; gate_lo = 4'b0010; arm_cur = -16'sd5; step();
        gate_hi = 4'b0001; gate_lo = 4'b0001; arm_cur = -16'sd900; step();
        // R7: lower arm adds the sum
        gate_hi = '1; gate_lo = '0; arm_cur = 16'sd10; lower_arm = 1;
        dc_volt = -16'sd1000; step();
        // R8: clamp high and low
        set_cv(10000, 10000, 10000, 10000); dc_volt = 16'sd30000; step();
        lower_arm = 0; dc_volt = -16'sd30000; step();
        set_cv(-32768, -32768, -32768, -32768); lower_arm = 1; dc_volt = -16'sd32768; step();
        lower_arm = 0; dc_volt = 16'sd32767; step();

        // mixed pseudo-random patterns
        for (int n = 0; n < 400; n++) begin
            gate_hi = NSM'($urandom);
            gate_lo = NSM'($urandom);
            arm_cur = IW'($urandom);
            cap_volt = {$urandom, $urandom};
            dc_volt = VW'($urandom);
            lower_arm = 1'($urandom);
            step();
        end

        // back into reset: outputs return to zero (R9)
        rst = 1'b1;
        @(negedge clk);
        check("R9", "arm_volt after reset", int'(arm_volt), 0);
        check("R9", "sw_hi after reset", int'(sw_hi), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule